// File: doc/BRIEF.md
# Configuration Register and Interrupt Pin Gating

This block holds the main configuration register of a supply and temperature monitor, together with the interrupt status, a per-source interrupt mask and the logic that drives the active-low interrupt pin. Software reaches it over a simple register bus with one-cycle write and read strobes. The read data is registered, so it is valid in the cycle after the read strobe. Event pulses from the measurement logic come in on an event vector. Each pulse sets a sticky status bit. A status bit can pull the pin low only when the configuration allows it and the mask does not block that bit.

The configuration register has a self-clearing soft-reset bit. Writing it produces a one-cycle reset pulse. The pulse returns the configuration, mask and status to their power-on values. Two registers are left as they were: a test register and an analog output register. The same pulse leaves the block on a port so that neighbouring logic can reinitialize as well.

Top module: `mon_cfg_irq`

## Requirements
- R1: After power-on reset the configuration (0x40), status (0x41), mask (0x42), test (0x13) and analog output (0x19) registers read 0x00, the interrupt pin is high and the soft-reset output is low.
- R2: A write to address 0x40 stores the data, and a read returns it in the cycle after the read strobe. Bit 4 is never stored.
- R3: A write to 0x40 with bit 4 set drives the soft-reset output high for exactly the one cycle after the write. Bit 4 reads 0 after that cycle.
- R4: During the soft-reset cycle the configuration, mask and status registers return to their power-on values. The pulse takes priority over a bus write or event in the same cycle.
- R5: Soft reset leaves the test register (0x13) and the analog output register (0x19) unchanged.
- R6: The interrupt pin is low only when configuration bit 1 (enable) is 1, configuration bit 2 (clear) is 0, and at least one unmasked status bit is set.
- R7: A pulse on bit i of the event input sets status bit i in the next cycle, whatever the enable, clear and mask settings. The bit stays set until it is read or a reset occurs.
- R8: Reading 0x41 returns the status and clears it. An event that arrives in the same cycle as the read stays set.
- R9: Mask register 0x42 is read/write. Setting bit i prevents status bit i from pulling the pin low.
- R10: Writes to the status address or to unmapped addresses change nothing. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| events | input | 8 | Interrupt event pulses, one per source |
| irqN | output | 1 | Interrupt pin, active low |
| softRstPulse | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench sets the enable bit while the clear bit is still 1, and also clears the enable bit while a status bit is pending. A design that gated only on the enable bit would pull the pin low in these cases, and one that gated the status capture as well would lose the event. It reads the status in the same cycle as a new event; a design that let the read win would drop that event. It fires a soft reset with test, analog output, mask and status all non-zero. A design that reset everything, or left the mask or status alone, returns the wrong readback. A soft-reset pulse that lasted two cycles, or a bit 4 that stuck, shows up on the pulse output and in the configuration readback.

// File: rtl/mon_cfg_irq_pkg.sv
package mon_cfg_irq_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_STAT,
    SEL_MASK,
    SEL_TEST,
    SEL_AOUT
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   wrCfg;
    logic   wrMask;
    logic   wrTest;
    logic   wrAout;
    logic   rdStat;
    logic   softRst;
    logic   rdLoad;
    rdSel_e sel;
  } ctrlStrb_t;

endpackage

// File: rtl/mon_cfg_irq_ctrl.sv
module mon_cfg_irq_ctrl
  import mon_cfg_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SRST_BIT = 4,
  parameter logic [AW-1:0] ADDR_CFG  = 8'h40,
  parameter logic [AW-1:0] ADDR_STAT = 8'h41,
  parameter logic [AW-1:0] ADDR_MASK = 8'h42,
  parameter logic [AW-1:0] ADDR_TEST = 8'h13,
  parameter logic [AW-1:0] ADDR_AOUT = 8'h19
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output ctrlStrb_t     strb
);

  logic softPulse;
  logic hitCfg, hitStat, hitMask, hitTest, hitAout;

  assign hitCfg  = (addr == ADDR_CFG);
  assign hitStat = (addr == ADDR_STAT);
  assign hitMask = (addr == ADDR_MASK);
  assign hitTest = (addr == ADDR_TEST);
  assign hitAout = (addr == ADDR_AOUT);

  // the soft-reset request is registered into a one-cycle pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softPulse <= 1'b0;
    else       softPulse <= wrEn && hitCfg && wrData[SRST_BIT];
  end

  always_comb begin
    strb.wrCfg   = wrEn && hitCfg;
    strb.wrMask  = wrEn && hitMask;
    strb.wrTest  = wrEn && hitTest;
    strb.wrAout  = wrEn && hitAout;
    strb.rdStat  = rdEn && hitStat;
    strb.softRst = softPulse;
    strb.rdLoad  = rdEn;
    if (hitCfg)       strb.sel = SEL_CFG;
    else if (hitStat) strb.sel = SEL_STAT;
    else if (hitMask) strb.sel = SEL_MASK;
    else if (hitTest) strb.sel = SEL_TEST;
    else if (hitAout) strb.sel = SEL_AOUT;
    else              strb.sel = SEL_NONE;
  end

  // R3: a pulse lasts one cycle unless a fresh write re-arms it
  assert_pulse_once_R3: assert property (@(posedge clk) disable iff (!rstN)
    (softPulse && !wrEn) |=> !softPulse);

  // R3: a pulse only follows a configuration write
  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softPulse) |-> ($past(wrEn) && $past(addr) == ADDR_CFG));

endmodule

// File: rtl/mon_cfg_irq_dp.sv
module mon_cfg_irq_dp
  import mon_cfg_irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int EN_BIT = 1,
  parameter int CLR_BIT = 2,
  parameter int SRST_BIT = 4,
  parameter logic [DW-1:0] CFG_INIT = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] events,
  output logic [DW-1:0] rdData,
  output logic          irqN
);

  localparam logic [DW-1:0] SRST_M     = DW'(1) << SRST_BIT;
  localparam logic [DW-1:0] CFG_INIT_C = CFG_INIT & ~SRST_M;

  logic [DW-1:0] cfg, maskReg, stat, testReg, aoutReg;
  logic          irqActive;

  // registers cleared by soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= CFG_INIT_C;
      maskReg <= '0;
    end else if (strb.softRst) begin
      cfg     <= CFG_INIT_C;
      maskReg <= '0;
    end else begin
      if (strb.wrCfg)  cfg     <= wrData & ~SRST_M;
      if (strb.wrMask) maskReg <= wrData;
    end
  end

  // registers that survive soft reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testReg <= '0;
      aoutReg <= '0;
    end else begin
      if (strb.wrTest) testReg <= wrData;
      if (strb.wrAout) aoutReg <= wrData;
    end
  end

  // sticky status, one bit per source; a new event beats clear-on-read
  for (genvar g = 0; g < DW; g++) begin : gStat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             stat[g] <= 1'b0;
      else if (strb.softRst) stat[g] <= 1'b0;
      else if (events[g])    stat[g] <= 1'b1;
      else if (strb.rdStat)  stat[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdLoad) begin
      unique case (strb.sel)
        SEL_CFG:  rdData <= cfg | (strb.softRst ? SRST_M : '0);
        SEL_STAT: rdData <= stat;
        SEL_MASK: rdData <= maskReg;
        SEL_TEST: rdData <= testReg;
        SEL_AOUT: rdData <= aoutReg;
        default:  rdData <= '0;
      endcase
    end
  end

  assign irqActive = cfg[EN_BIT] && !cfg[CLR_BIT] && |(stat & ~maskReg);
  assign irqN      = !irqActive;

  // R7: status bits never drop without a read or soft reset
  assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdStat && !strb.softRst) |=> ((stat & $past(stat)) == $past(stat)));

  // R8: an event always lands, even alongside a status read
  assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.softRst && |events) |=> ((stat & $past(events)) == $past(events)));

  // R4: soft reset returns the resettable state to its initial values
  assert_soft_init_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (cfg == CFG_INIT_C && maskReg == '0 && stat == '0));

  // R5: soft reset leaves the preserved registers alone
  assert_keep_test_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.softRst && !strb.wrTest && !strb.wrAout) |=> ($stable(testReg) && $stable(aoutReg)));

  // R6: the pin never asserts unless the gating allows it
  assert_pin_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (cfg[EN_BIT] && !cfg[CLR_BIT]));

  // R2: bit 4 is never held in the stored configuration
  assert_no_srst_store_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCfg |=> !cfg[SRST_BIT]);

endmodule

// File: rtl/mon_cfg_irq.sv
module mon_cfg_irq
  import mon_cfg_irq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int EN_BIT = 1,
  parameter int CLR_BIT = 2,
  parameter int SRST_BIT = 4,
  parameter logic [DW-1:0] CFG_INIT  = 8'h00,
  parameter logic [AW-1:0] ADDR_CFG  = 8'h40,
  parameter logic [AW-1:0] ADDR_STAT = 8'h41,
  parameter logic [AW-1:0] ADDR_MASK = 8'h42,
  parameter logic [AW-1:0] ADDR_TEST = 8'h13,
  parameter logic [AW-1:0] ADDR_AOUT = 8'h19
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [DW-1:0] events,
  output logic          irqN,
  output logic          softRstPulse
);

  ctrlStrb_t strb;

  mon_cfg_irq_ctrl #(
    .AW(AW), .DW(DW), .SRST_BIT(SRST_BIT),
    .ADDR_CFG(ADDR_CFG), .ADDR_STAT(ADDR_STAT), .ADDR_MASK(ADDR_MASK),
    .ADDR_TEST(ADDR_TEST), .ADDR_AOUT(ADDR_AOUT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .strb(strb)
  );

  mon_cfg_irq_dp #(
    .DW(DW), .EN_BIT(EN_BIT), .CLR_BIT(CLR_BIT),
    .SRST_BIT(SRST_BIT), .CFG_INIT(CFG_INIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .events(events), .rdData(rdData), .irqN(irqN)
  );

  assign softRstPulse = strb.softRst;

endmodule

// File: tb/test_mon_cfg_irq.sv
module test_mon_cfg_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] events = '0;
  logic [7:0] rdData;
  logic       irqN;
  logic       softRstPulse;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];
  logic rdSeen = 1'b0;

  always #2.5 clk = ~clk;

  mon_cfg_irq i_mon_cfg_irq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .events(events), .irqN(irqN),
    .softRstPulse(softRstPulse)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected value for each read issued a cycle earlier
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      item_t it;
      if (q.size() == 0) chk(1'b0, "scoreboard empty", rdData, 8'h00);
      else begin
        it = q.pop_front();
        chk(rdData == it.exp, it.tag, rdData, it.exp);
      end
    end
  end

  // driver tasks: start and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseEv(input logic [7:0] d);
    events = d;
    @(negedge clk);
    events = '0;
  endtask

  task automatic chkPin(input logic exp, input string tag);
    chk(irqN == exp, tag, {7'b0, irqN}, {7'b0, exp});
  endtask

  task automatic chkPulse(input logic exp, input string tag);
    chk(softRstPulse == exp, tag, {7'b0, softRstPulse}, {7'b0, exp});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkPin(1'b1, "R1 pin idle");
    chkPulse(1'b0, "R1 pulse idle");
    rd(8'h40, 8'h00, "R1 cfg");
    rd(8'h41, 8'h00, "R1 stat");
    rd(8'h42, 8'h00, "R1 mask");
    rd(8'h13, 8'h00, "R1 test");
    rd(8'h19, 8'h00, "R1 aout");

    // R2 readback, enable=1 clear=0
    wr(8'h40, 8'h2B);
    rd(8'h40, 8'h2B, "R2 cfg readback");

    // R6/R7/R8 basic interrupt flow
    pulseEv(8'h05);
    chkPin(1'b0, "R6 pin asserted");
    rd(8'h41, 8'h05, "R7 stat latched");
    chkPin(1'b1, "R8 pin released after read");
    rd(8'h41, 8'h00, "R8 stat cleared");

    // R9 masking
    wr(8'h42, 8'h01);
    pulseEv(8'h01);
    chkPin(1'b1, "R9 masked source");
    rd(8'h42, 8'h01, "R9 mask readback");
    pulseEv(8'h02);
    chkPin(1'b0, "R9 unmasked source");
    rd(8'h41, 8'h03, "R7 masked bit still latched");

    // R8 event in the same cycle as the read
    pulseEv(8'h04);
    events = 8'h08;
    rd(8'h41, 8'h04, "R8 read with new event");
    events = '0;
    rd(8'h41, 8'h08, "R8 new event kept");

    // R6 gating: enable with clear still 1, then enable off
    wr(8'h40, 8'h06);
    pulseEv(8'h20);
    chkPin(1'b1, "R6 clear bit blocks pin");
    rd(8'h41, 8'h20, "R7 latched while blocked");
    wr(8'h40, 8'h00);
    pulseEv(8'h40);
    chkPin(1'b1, "R6 enable off blocks pin");
    wr(8'h40, 8'h02);
    chkPin(1'b0, "R6 pending bit drives pin once enabled");
    rd(8'h41, 8'h40, "R7 latched while disabled");
    chkPin(1'b1, "R8 pin released");

    // R4/R5 soft reset with everything non-zero
    wr(8'h13, 8'hA5);
    wr(8'h19, 8'h3C);
    wr(8'h42, 8'h0F);
    pulseEv(8'h80);
    wr(8'h40, 8'h12);
    chkPulse(1'b1, "R3 pulse high");
    @(negedge clk);
    chkPulse(1'b0, "R3 pulse one cycle");
    chkPin(1'b1, "R4 pin after soft reset");
    rd(8'h40, 8'h00, "R3 R4 cfg after soft reset");
    rd(8'h42, 8'h00, "R4 mask after soft reset");
    rd(8'h41, 8'h00, "R4 stat after soft reset");
    rd(8'h13, 8'hA5, "R5 test kept");
    rd(8'h19, 8'h3C, "R5 aout kept");

    // R10 ignored writes and unmapped reads
    pulseEv(8'h01);
    wr(8'h41, 8'hFE);
    rd(8'h41, 8'h01, "R10 status write ignored");
    wr(8'h7E, 8'h55);
    rd(8'h7E, 8'h00, "R10 unmapped read");
    rd(8'h40, 8'h00, "R10 cfg untouched");
    rd(8'h13, 8'hA5, "R10 test untouched");

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule